// File: doc/BRIEF.md
# Board System-Control Register File

This block is the small control register bank that a development board exposes on a simple 32-bit read/write bus. It sits behind a window addressed by a 20-bit offset. Any higher address bits are ignored. Through it, software drives a row of eight LEDs and an eight-character ASCII display. It can also raise a one-shot system reset request by writing a magic value, and it keeps a break/reset byte and a general output byte. It also provides a set of bit-bang registers that wiggle the clock and data lines of an attached serial EEPROM.

The display can be loaded one character at a time, or from a single 32-bit word. A word write is expanded into eight uppercase hexadecimal digits, with the most significant nibble in character 0. The EEPROM data line comes back on the I2C input register. A loopback input returns the I2C output word when the select bit is set. A status word reports the byte order chosen by a parameter.

Reads and writes each take one cycle. Read data is registered and appears in the cycle after the read strobe. It is zero in any cycle that follows no read. The block has no state machine: every register updates directly from the decoded write strobe, and the read path is one registered multiplexer.

Top module: `sysctl_regfile`

## Requirements
- R1: Only `bus_addr[19:0]` is decoded. Any offset not listed here, including a misaligned offset inside the character range such as 0x41C, reads as zero, and a write to it changes no output and no readable register.
- R2: A read strobe in cycle n puts the addressed value on `bus_rdata` in cycle n+1. In a cycle that follows no read, `bus_rdata` is zero. After reset, `bus_rdata` is zero.
- R3: Offset 0x408 is the LED register. A write keeps `wdata[7:0]`, and that value is read back zero-extended and driven on `leds_o`. It resets to 0x00.
- R4: A write to offset 0x410 sets display character i to the ASCII hex digit of `wdata[31-4i:28-4i]`. Digits 0-9 become 0x30-0x39 and digits A-F become 0x41-0x46. This offset reads zero.
- R5: A write to offset 0x418+8·i, for i from 0 to 7, sets display character i to `wdata[7:0]`. Character i is output on `disp_o[8i+7:8i]`. All characters reset to 0x20.
- R6: A write of exactly 0x00000042 to offset 0x500 raises `reset_req_o` in the next cycle, for that one cycle. A write of any other value there leaves it low.
- R7: Offset 0x508 is an 8-bit break/reset byte that resets to 0x0A. Offset 0xA00 is an 8-bit general output byte that resets to 0x00. Both keep `wdata[7:0]` on a write and read back zero-extended.
- R8: Offset 0xB08 is a 2-bit output-enable field, kept from `wdata[1:0]`, with reset value 0. Offset 0xB18 is a 1-bit select, kept from `wdata[0]`, with reset value 1.
- R9: Offset 0xB10 stores the full 32-bit I2C output word, which resets to 0x00000003 and reads back whole. `i2c_scl_o` follows bit 1 of the word and `i2c_sda_o` follows bit 0, from the cycle after each write.
- R10: Offset 0xB00 reads 0x00000002 with bit 0 replaced by `eeprom_sda_i`, sampled at the read edge.
- R11: Offset 0xA08 reads the I2C output word when the select bit is 1, and reads zero when it is 0.
- R12: Offsets 0x200 and 0x210 read zero. Offset 0x208 reads 0x12 when `BIG_ENDIAN` is 1 and 0x10 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address; only the low 20 bits are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| leds_o | output | 8 | LED bar bits |
| disp_o | output | 64 | Display characters, character i in bits 8i+7:8i |
| reset_req_o | output | 1 | One-cycle system reset request |
| i2c_scl_o | output | 1 | EEPROM clock drive value |
| i2c_sda_o | output | 1 | EEPROM data drive value |
| eeprom_sda_i | input | 1 | Data line returned by the EEPROM |

## Verification
The bench builds the block with `BIG_ENDIAN` set to 0 and all other parameters at their defaults. This brings the little-endian status value 0x10 within reach. The upper twelve address bits are driven non-zero on many accesses, which exercises the 20-bit decode. The default eight-character display lets every per-character offset be reached, along with the misaligned gap just after the first one. The default eight-character display also lets a whole-word hex expansion be checked digit by digit, covering both the numeric and the alphabetic ASCII ranges.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // register offsets inside the decoded window
    localparam int unsigned OFF_SWITCH  = 32'h200;
    localparam int unsigned OFF_STATUS  = 32'h208;
    localparam int unsigned OFF_JUMPER  = 32'h210;
    localparam int unsigned OFF_LED     = 32'h408;
    localparam int unsigned OFF_WORD    = 32'h410;
    localparam int unsigned OFF_CHAR0   = 32'h418;
    localparam int unsigned CHAR_STRIDE = 8;
    localparam int unsigned OFF_SOFTRES = 32'h500;
    localparam int unsigned OFF_BRK     = 32'h508;
    localparam int unsigned OFF_GPOUT   = 32'hA00;
    localparam int unsigned OFF_GPIN    = 32'hA08;
    localparam int unsigned OFF_I2CIN   = 32'hB00;
    localparam int unsigned OFF_I2COE   = 32'hB08;
    localparam int unsigned OFF_I2COUT  = 32'hB10;
    localparam int unsigned OFF_I2CSEL  = 32'hB18;

    localparam logic [31:0] SOFTRES_KEY = 32'h0000_0042;
    localparam logic [31:0] I2C_IN_RST  = 32'h0000_0003;
    localparam logic [31:0] I2C_OUT_RST = 32'h0000_0003;
    localparam logic [7:0]  BRK_RST     = 8'h0A;
    localparam logic [7:0]  BLANK_CHAR  = 8'h20;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_STATUS,
        SEL_JUMPER,
        SEL_LED,
        SEL_WORD,
        SEL_CHAR,
        SEL_SOFTRES,
        SEL_BRK,
        SEL_GPOUT,
        SEL_GPIN,
        SEL_I2CIN,
        SEL_I2COE,
        SEL_I2COUT,
        SEL_I2CSEL
    } reg_sel_e;

    function automatic logic [7:0] hex_digit(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int DEC_W     = 20,
    parameter int NUM_CHARS = 8,
    localparam int IDX_W    = $clog2(NUM_CHARS)
) (
    input  logic [DEC_W-1:0] off,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] char_idx
);
    localparam logic [DEC_W-1:0] CHAR_FIRST = DEC_W'(OFF_CHAR0);
    localparam logic [DEC_W-1:0] CHAR_LAST  = DEC_W'(OFF_CHAR0 + CHAR_STRIDE * (NUM_CHARS - 1));
    localparam int               STRIDE_SH  = $clog2(CHAR_STRIDE);

    logic [DEC_W-1:0] rel;

    always_comb begin
        sel      = SEL_NONE;
        char_idx = '0;
        rel      = off - CHAR_FIRST;
        if (off >= CHAR_FIRST && off <= CHAR_LAST && rel[STRIDE_SH-1:0] == '0) begin
            sel      = SEL_CHAR;
            char_idx = rel[STRIDE_SH +: IDX_W];
        end else begin
            case (off)
                DEC_W'(OFF_SWITCH):  sel = SEL_SWITCH;
                DEC_W'(OFF_STATUS):  sel = SEL_STATUS;
                DEC_W'(OFF_JUMPER):  sel = SEL_JUMPER;
                DEC_W'(OFF_LED):     sel = SEL_LED;
                DEC_W'(OFF_WORD):    sel = SEL_WORD;
                DEC_W'(OFF_SOFTRES): sel = SEL_SOFTRES;
                DEC_W'(OFF_BRK):     sel = SEL_BRK;
                DEC_W'(OFF_GPOUT):   sel = SEL_GPOUT;
                DEC_W'(OFF_GPIN):    sel = SEL_GPIN;
                DEC_W'(OFF_I2CIN):   sel = SEL_I2CIN;
                DEC_W'(OFF_I2COE):   sel = SEL_I2COE;
                DEC_W'(OFF_I2COUT):  sel = SEL_I2COUT;
                DEC_W'(OFF_I2CSEL):  sel = SEL_I2CSEL;
                default:             sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_display.sv
module sysctl_display
    import sysctl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_CHARS = 8,
    localparam int IDX_W    = $clog2(NUM_CHARS),
    localparam int DISP_W   = 8 * NUM_CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_word,
    input  logic              wr_char,
    input  logic [IDX_W-1:0]  char_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DISP_W-1:0] disp
);
    for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
        localparam int NIB_LO = DATA_W - 4 * (i + 1);
        logic [7:0] ch_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                ch_q <= BLANK_CHAR;
            else if (wr_word)
                ch_q <= hex_digit(wdata[NIB_LO +: 4]);
            else if (wr_char && char_idx == IDX_W'(i))
                ch_q <= wdata[7:0];
        end
        assign disp[8*i +: 8] = ch_q;
    end

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_word) && !$past(wr_char) |-> $stable(disp)); // R5

endmodule

// File: rtl/sysctl_i2c_regs.sv
module sysctl_i2c_regs
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_oe,
    input  logic              wr_out,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [OE_W-1:0]   oe_q,
    output logic [DATA_W-1:0] out_q,
    output logic              sel_q,
    output logic              scl,
    output logic              sda
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= '0;
            out_q <= DATA_W'(I2C_OUT_RST);
            sel_q <= 1'b1;
        end else begin
            if (wr_oe)  oe_q  <= wdata[OE_W-1:0];
            if (wr_out) out_q <= wdata;
            if (wr_sel) sel_q <= wdata[0];
        end
    end

    assign scl = out_q[1];
    assign sda = out_q[0];

    AST_I2C_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_out) |-> $stable({scl, sda})); // R9

    AST_I2C_LINES_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> {scl, sda} == $past(wdata[1:0])); // R9

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DEC_W      = 20,
    parameter int DATA_W     = 32,
    parameter int LED_W      = 8,
    parameter int BYTE_W     = 8,
    parameter int OE_W       = 2,
    parameter int NUM_CHARS  = 8,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int IDX_W     = $clog2(NUM_CHARS),
    localparam int DISP_W    = 8 * NUM_CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LED_W-1:0]  leds_o,
    output logic [DISP_W-1:0] disp_o,
    output logic              reset_req_o,
    output logic              i2c_scl_o,
    output logic              i2c_sda_o,
    input  logic              eeprom_sda_i
);
    localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? DATA_W'(32'h12) : DATA_W'(32'h10);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  char_idx;
    logic              unused_addr_hi;

    logic [LED_W-1:0]  led_q;
    logic [BYTE_W-1:0] brk_q;
    logic [BYTE_W-1:0] gp_q;
    logic [OE_W-1:0]   oe_q;
    logic [DATA_W-1:0] i2c_out_q;
    logic              i2c_sel_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              req_q;

    assign unused_addr_hi = ^bus_addr[ADDR_W-1:DEC_W];

    sysctl_decode #(.DEC_W(DEC_W), .NUM_CHARS(NUM_CHARS)) u_decode (
        .off      (bus_addr[DEC_W-1:0]),
        .sel      (sel),
        .char_idx (char_idx)
    );

    sysctl_display #(.DATA_W(DATA_W), .NUM_CHARS(NUM_CHARS)) u_display (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_word  (bus_wr && sel == SEL_WORD),
        .wr_char  (bus_wr && sel == SEL_CHAR),
        .char_idx (char_idx),
        .wdata    (bus_wdata),
        .disp     (disp_o)
    );

    sysctl_i2c_regs #(.DATA_W(DATA_W), .OE_W(OE_W)) u_i2c (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_oe  (bus_wr && sel == SEL_I2COE),
        .wr_out (bus_wr && sel == SEL_I2COUT),
        .wr_sel (bus_wr && sel == SEL_I2CSEL),
        .wdata  (bus_wdata),
        .oe_q   (oe_q),
        .out_q  (i2c_out_q),
        .sel_q  (i2c_sel_q),
        .scl    (i2c_scl_o),
        .sda    (i2c_sda_o)
    );

    // byte-wide control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= '0;
            brk_q <= BYTE_W'(BRK_RST);
            gp_q  <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_LED:   led_q <= bus_wdata[LED_W-1:0];
                SEL_BRK:   brk_q <= bus_wdata[BYTE_W-1:0];
                SEL_GPOUT: gp_q  <= bus_wdata[BYTE_W-1:0];
                default: ;
            endcase
        end
    end

    // soft reset request: one pulse per matching write
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= bus_wr && sel == SEL_SOFTRES && bus_wdata == DATA_W'(SOFTRES_KEY);
    end

    // read multiplexer
    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_STATUS: rd_val = STATUS_VAL;
            SEL_LED:    rd_val = DATA_W'(led_q);
            SEL_BRK:    rd_val = DATA_W'(brk_q);
            SEL_GPOUT:  rd_val = DATA_W'(gp_q);
            SEL_GPIN:   rd_val = i2c_sel_q ? i2c_out_q : '0;
            SEL_I2CIN:  rd_val = {I2C_IN_RST[DATA_W-1:1], eeprom_sda_i};
            SEL_I2COE:  rd_val = DATA_W'(oe_q);
            SEL_I2COUT: rd_val = i2c_out_q;
            SEL_I2CSEL: rd_val = DATA_W'(i2c_sel_q);
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign bus_rdata   = rdata_q;
    assign leds_o      = led_q;
    assign reset_req_o = req_q;

    AST_RSTREQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> $past(bus_wr) && $past(bus_wdata) == DATA_W'(SOFTRES_KEY)); // R6

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> bus_rdata == '0); // R2

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(leds_o)); // R3

endmodule

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  leds_o;
    logic [63:0] disp_o;
    logic        reset_req_o;
    logic        i2c_scl_o;
    logic        i2c_sda_o;
    logic        eeprom_sda_i = 1'b1;

    always #5 clk = ~clk;

    sysctl_regfile #(.BIG_ENDIAN(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .leds_o(leds_o), .disp_o(disp_o), .reset_req_o(reset_req_o),
        .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .eeprom_sda_i(eeprom_sda_i)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference state
    int unsigned m_led, m_brk, m_gp, m_oe, m_out, m_sel, m_rdata, m_req;
    byte unsigned m_ch[8];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int unsigned m_read(input int unsigned off, input bit sda);
        case (off)
            32'h208: return 32'h10;
            32'h408: return m_led;
            32'h508: return m_brk;
            32'hA00: return m_gp;
            32'hA08: return (m_sel != 0) ? m_out : 0;
            32'hB00: return 32'h2 | sda;
            32'hB08: return m_oe;
            32'hB10: return m_out;
            32'hB18: return m_sel;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] m_disp();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = m_ch[i];
        return v;
    endfunction

    task automatic m_reset();
        m_led = 0; m_brk = 8'h0A; m_gp = 0; m_oe = 0; m_out = 3; m_sel = 1;
        m_rdata = 0; m_req = 0;
        for (int i = 0; i < 8; i++) m_ch[i] = 8'h20;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " rdata R2"}, {32'h0, bus_rdata}, {32'h0, m_rdata});
        chk("leds R3", {56'h0, leds_o}, {56'h0, m_led[7:0]});
        chk({tag, " display R5"}, disp_o, m_disp());
        chk("reset request R6", {63'h0, reset_req_o}, {63'h0, m_req[0]});
        chk("i2c lines R9", {62'h0, i2c_scl_o, i2c_sda_o}, {62'h0, m_out[1:0]});
    endtask

    // one bus cycle; called at a falling edge, returns at the next one
    task automatic cyc(input bit wr, input bit rd, input logic [31:0] addr,
                       input logic [31:0] d, input bit sda, input string tag);
        int unsigned off;
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = d; eeprom_sda_i = sda;
        @(posedge clk);
        off = addr & 32'hFFFFF;
        m_rdata = rd ? m_read(off, sda) : 0;
        m_req = (wr && off == 32'h500 && d == 32'h42) ? 1 : 0;
        if (wr) begin
            if (off == 32'h408) m_led = d & 8'hFF;
            else if (off == 32'h410) begin
                for (int i = 0; i < 8; i++) begin
                    int unsigned nib = (d >> (28 - 4 * i)) & 4'hF;
                    m_ch[i] = (nib < 10) ? byte'(48 + nib) : byte'(55 + nib);
                end
            end
            else if (off >= 32'h418 && off <= 32'h450 && (off % 8) == 0)
                m_ch[(off - 32'h418) / 8] = d[7:0];
            else if (off == 32'h508) m_brk = d & 8'hFF;
            else if (off == 32'hA00) m_gp = d & 8'hFF;
            else if (off == 32'hB08) m_oe = d & 3;
            else if (off == 32'hB10) m_out = d;
            else if (off == 32'hB18) m_sel = d & 1;
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        compare_all(tag);
    endtask

    task automatic rd(input logic [31:0] off, input string tag);
        cyc(0, 1, 32'hABC0_0000 | off, 32'h0, 1'b1, tag);
    endtask

    task automatic wr(input logic [31:0] off, input logic [31:0] d, input string tag);
        cyc(1, 0, 32'h5530_0000 | off, d, 1'b1, tag);
    endtask

    initial begin : watchdog
        while (!finished && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        cyc(0, 0, 32'h0, 32'h0, 1'b1, "reset state R2");
        rd(32'h200, "switch R12");
        rd(32'h208, "status R12");
        rd(32'h210, "jumper R12");
        rd(32'h408, "led reset R3");
        rd(32'h508, "break reset R7");
        rd(32'hA00, "gpout reset R7");
        rd(32'hB08, "oe reset R8");
        rd(32'hB18, "select reset R8");
        rd(32'hB10, "i2c out reset R9");
        rd(32'hA08, "loopback R11");
        cyc(0, 1, 32'h0000_0B00, 32'h0, 1'b0, "i2c in sda0 R10");
        cyc(0, 1, 32'hFFF0_0B00, 32'h0, 1'b1, "i2c in sda1 R10");
        // LED bar
        wr(32'h408, 32'h0000_01A5, "led write R3");
        rd(32'h408, "led read R3");
        // word to hex text
        wr(32'h410, 32'h12AB_9CF0, "hex word R4");
        wr(32'h410, 32'hDEAD_BEEF, "hex word R4");
        rd(32'h410, "word reads zero R4");
        // single characters
        wr(32'h418, 32'h1234_5641, "char0 R5");
        wr(32'h430, 32'h0000_007A, "char3 R5");
        wr(32'h450, 32'hFFFF_FF21, "char7 R5");
        wr(32'h41C, 32'h0000_0055, "misaligned ignored R1");
        wr(32'h458, 32'h0000_0055, "past last char ignored R1");
        // soft reset
        wr(32'h500, 32'h0000_0041, "wrong key R6");
        wr(32'h500, 32'h0000_0142, "wrong key upper R6");
        wr(32'h500, 32'h0000_0042, "key R6");
        cyc(0, 0, 32'h0, 32'h0, 1'b1, "pulse ends R6");
        // byte registers
        wr(32'hA00, 32'hFFFF_FF3C, "gpout write R7");
        wr(32'h508, 32'h1234_5655, "break write R7");
        rd(32'h508, "break read R7");
        rd(32'hA00, "gpout read R7");
        // I2C
        wr(32'hB08, 32'hFFFF_FFFF, "oe write R8");
        rd(32'hB08, "oe read R8");
        wr(32'hB10, 32'h0000_0000, "scl0 sda0 R9");
        wr(32'hB10, 32'h0000_0002, "scl1 sda0 R9");
        wr(32'hB10, 32'h0000_0001, "scl0 sda1 R9");
        wr(32'hB10, 32'hCAFE_F00D, "full word R9");
        rd(32'hB10, "out read R9");
        rd(32'hA08, "loopback on R11");
        wr(32'hB18, 32'h0000_0002, "select low R8");
        rd(32'hB18, "select read R8");
        rd(32'hA08, "loopback off R11");
        wr(32'hB18, 32'h0000_0003, "select high R8");
        rd(32'hA08, "loopback back on R11");
        // unlisted offsets
        wr(32'h300, 32'hFFFF_FFFF, "unlisted write R1");
        rd(32'h300, "unlisted read R1");
        wr(32'h0_0408 | 32'h0010_0000, 32'h0000_0077, "alias high bits R1");
        rd(32'h408, "alias read R1");
        rd(32'h204, "gap read R1");
        // idle after read
        rd(32'h508, "read before idle R2");
        cyc(0, 0, 32'h508, 32'h0, 1'b1, "idle zero R2");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule